// File: doc/BRIEF.md
# Hashed Exact-Match Flow Table

This block keeps a small table of wide flow keys, such as 104-bit 5-tuples, and answers exact-match queries on it. An incoming key is folded by a fixed hash into a narrow slot number. The full key stored in that slot is compared with the incoming key. When the slot holds a different key, the engine moves to the next slot, and it examines at most four slots in total. The walk ends at the first slot that matches, at the first empty slot, or when the four slots have been tried. Lookups report whether the key is present and where it is. Inserts put an absent key into the first free slot on its walk. The table has twice as many slots as the number of flows it is sized for, which leaves room for keys whose hashes collide.

Requests arrive on a valid/ready channel and results leave on another. The engine handles one operation at a time. `req_ready` is high only when the engine is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. When the result is ready, `rsp_valid` goes high and stays high, with every result field held steady, until the consumer raises `rsp_ready`. The next request is accepted only after that. Latency varies with the number of slots examined.

Top module: `flow_hash_table`

## Requirements
- R1: After reset every slot is empty, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The home slot of a key is found as follows. Split the key, zero-padded, into IDX_W-bit chunks, with chunk 0 taken from the least significant bits. Rotate chunk c left by (c mod IDX_W) bits. XOR all the rotated chunks together. An insert into an empty table lands in this home slot.
- R3: A lookup of a stored key returns `rsp_hit`=1 and `rsp_idx` equal to the slot that holds the key.
- R4: The slots examined are home, home+1, home+2 and home+3, taken modulo the table depth, so the walk wraps from the last slot to slot 0.
- R5: A lookup that reaches an empty slot before finding a match ends there with `rsp_hit`=0. The empty slot is counted in `rsp_probes`.
- R6: An insert of an absent key writes it into the first empty slot on its walk. The result has `rsp_hit`=1, `rsp_new`=1 and `rsp_idx` set to that slot. No occupied slot is ever written.
- R7: An insert of a key that is already stored reports `rsp_hit`=1, `rsp_new`=0 and the existing slot, and it adds no second copy.
- R8: An insert that finds all four slots on its walk occupied by other keys reports `rsp_full`=1, `rsp_hit`=0 and `rsp_probes`=4, and it leaves the table unchanged.
- R9: A lookup that finds four occupied, non-matching slots reports a miss with `rsp_probes`=4.
- R10: `rsp_valid` rises exactly 1+P cycles after the accepting edge, where P is the value reported in `rsp_probes` (from 1 to 4).
- R11: `req_ready` stays low from the accepting edge until the result is consumed. While `rsp_valid`=1 and `rsp_ready`=0, all result fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 1 | Operation: 0 lookup, 1 insert |
| req_key | input | KEY_W | Flow key |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Key is in the table at `rsp_idx` after the operation |
| rsp_new | output | 1 | Insert stored the key in a free slot |
| rsp_full | output | 1 | Insert failed because the walk was exhausted |
| rsp_idx | output | IDX_W | Slot index; meaningful when `rsp_hit`=1 |
| rsp_probes | output | PW | Number of slots examined |

## Verification
The hardest situations to reach are long collision chains: a walk that uses all four slots, and a walk that wraps past the last slot. Random keys almost never produce them. The bench reaches them on purpose. Because chunk 0 enters the hash without rotation, the bench can choose the low IDX_W bits of an otherwise arbitrary key so that the key hashes to any home slot it wants. It then stacks several distinct keys on slot 7 and on the last slot. A lookup for a further key whose home slot lies inside an existing chain shows early termination at a later empty slot.

// File: rtl/flow_tbl_pkg.sv
package flow_tbl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HASH  = 2'd1,
    ST_PROBE = 2'd2,
    ST_RESP  = 2'd3
  } probe_state_e;

  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_INSERT = 1'b1
  } flow_op_e;

endpackage

// File: rtl/flow_hash_fold.sv
module flow_hash_fold #(
  parameter int KEY_W = 104,
  parameter int IDX_W = 5
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  localparam int NCH  = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PADW = NCH * IDX_W;

  logic [PADW-1:0]  padded;
  logic [IDX_W-1:0] rot [NCH];

  assign padded = PADW'(key);

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    localparam int R = c % IDX_W;
    logic [IDX_W-1:0] chunk;
    assign chunk = padded[c*IDX_W +: IDX_W];
    if (R == 0) begin : g_plain
      assign rot[c] = chunk;
    end else begin : g_rot
      assign rot[c] = {chunk[IDX_W-1-R:0], chunk[IDX_W-1:IDX_W-R]};
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) idx = idx ^ rot[i];
  end
endmodule

// File: rtl/flow_key_store.sv
module flow_key_store #(
  parameter int KEY_W = 104,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] slot_vld;
  logic [KEY_W-1:0] slot_key [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) slot_vld <= '0;
    else if (wr_en) slot_vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_key[wr_idx] <= wr_key;
  end

  assign rd_valid = slot_vld[rd_idx];
  assign rd_key   = slot_key[rd_idx];

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !slot_vld[wr_idx]); // R6
endmodule

// File: rtl/flow_probe_ctrl.sv
module flow_probe_ctrl
  import flow_tbl_pkg::*;
#(
  parameter int KEY_W  = 104,
  parameter int IDX_W  = 5,
  parameter int PROBES = 4,
  parameter int PW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [KEY_W-1:0] req_key,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_new,
  output logic             rsp_full,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [PW-1:0]    rsp_probes,
  output logic [KEY_W-1:0] key_q,
  input  logic [IDX_W-1:0] hash_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [KEY_W-1:0] rd_key,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [KEY_W-1:0] wr_key
);
  localparam int CW = (PROBES > 1) ? $clog2(PROBES) : 1;

  probe_state_e     state;
  flow_op_e         op_q;
  logic [IDX_W-1:0] base_q;
  logic [CW-1:0]    cnt_q;
  logic             slot_match;
  logic             last_probe;

  assign rd_idx     = base_q + IDX_W'(cnt_q);
  assign slot_match = rd_valid && (rd_key == key_q);
  assign last_probe = (cnt_q == CW'(PROBES - 1));
  assign wr_en      = (state == ST_PROBE) && (op_q == OP_INSERT) && !rd_valid;
  assign wr_idx     = rd_idx;
  assign wr_key     = key_q;
  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_q       <= OP_LOOKUP;
      key_q      <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      rsp_hit    <= 1'b0;
      rsp_new    <= 1'b0;
      rsp_full   <= 1'b0;
      rsp_idx    <= '0;
      rsp_probes <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          key_q <= req_key;
          op_q  <= flow_op_e'(req_op);
          state <= ST_HASH;
        end
        ST_HASH: begin
          base_q <= hash_idx;
          cnt_q  <= '0;
          state  <= ST_PROBE;
        end
        ST_PROBE: begin
          rsp_idx    <= rd_idx;
          rsp_probes <= PW'(cnt_q) + PW'(1);
          if (slot_match) begin
            rsp_hit  <= 1'b1;
            rsp_new  <= 1'b0;
            rsp_full <= 1'b0;
            state    <= ST_RESP;
          end else if (!rd_valid) begin
            rsp_hit  <= (op_q == OP_INSERT);
            rsp_new  <= (op_q == OP_INSERT);
            rsp_full <= 1'b0;
            state    <= ST_RESP;
          end else if (last_probe) begin
            rsp_hit  <= 1'b0;
            rsp_new  <= 1'b0;
            rsp_full <= (op_q == OP_INSERT);
            state    <= ST_RESP;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_hit, rsp_new, rsp_full, rsp_idx, rsp_probes})); // R11
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11
  AST_PROBE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes >= 1) && (rsp_probes <= PROBES)); // R10
  AST_HIT_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_full)); // R8
  AST_FULL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_full |-> rsp_probes == PW'(PROBES)); // R8
  AST_NEW_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_new |-> rsp_hit); // R6
endmodule

// File: rtl/flow_hash_table.sv
module flow_hash_table #(
  parameter int KEY_W     = 104,
  parameter int MAX_FLOWS = 16,
  parameter int PROBES    = 4,
  localparam int IDX_W    = $clog2(2 * MAX_FLOWS),
  localparam int PW       = $clog2(PROBES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [KEY_W-1:0] req_key,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_new,
  output logic             rsp_full,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [PW-1:0]    rsp_probes
);
  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] hash_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid;
  logic [KEY_W-1:0] rd_key;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [KEY_W-1:0] wr_key;

  flow_hash_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
    .key (key_q),
    .idx (hash_idx)
  );

  flow_key_store #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_key   (rd_key),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_key   (wr_key)
  );

  flow_probe_ctrl #(.KEY_W(KEY_W), .IDX_W(IDX_W), .PROBES(PROBES), .PW(PW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_key    (req_key),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_hit    (rsp_hit),
    .rsp_new    (rsp_new),
    .rsp_full   (rsp_full),
    .rsp_idx    (rsp_idx),
    .rsp_probes (rsp_probes),
    .key_q      (key_q),
    .hash_idx   (hash_idx),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_key     (rd_key),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_key     (wr_key)
  );
endmodule

// File: tb/sim_flow_hash_table.sv
module sim_flow_hash_table;
  localparam int KW = 104;
  localparam int IW = 5;
  localparam int D  = 32;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [KW-1:0] req_key = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_hit, rsp_new, rsp_full;
  logic [IW-1:0] rsp_idx;
  logic [2:0]    rsp_probes;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic          mv [D];
  logic [KW-1:0] mk [D];

  always #4 clk = ~clk;

  flow_hash_table u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_key(req_key),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_new(rsp_new), .rsp_full(rsp_full),
    .rsp_idx(rsp_idx), .rsp_probes(rsp_probes)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, act cycles=%0d exp below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] ref_hash(input logic [KW-1:0] k);
    logic [IW-1:0] h = '0;
    for (int b = 0; b < KW; b++) begin
      int c = b / IW;
      int p = b % IW;
      h[(p + (c % IW)) % IW] ^= k[b];
    end
    return h;
  endfunction

  function automatic logic [KW-1:0] key_for(input logic [31:0] tag, input int home);
    logic [KW-1:0] k = {tag, ~tag, {3'b101, tag ^ 32'h3c3c_a5a5}, 5'b0};
    logic [IW-1:0] h0 = ref_hash(k);
    k[IW-1:0] = IW'(home) ^ h0;
    return k;
  endfunction

  task automatic run_op(input bit op, input logic [KW-1:0] key, input int hold,
                        input string tag);
    bit e_hit = 0, e_new = 0, e_full = 0, done = 0;
    int e_idx = 0, e_pr = 0;
    int h = ref_hash(key);
    for (int p = 0; p < NP && !done; p++) begin
      int s = (h + p) % D;
      e_pr = p + 1;
      if (mv[s] && mk[s] == key) begin
        e_hit = 1; e_idx = s; done = 1;
      end else if (!mv[s]) begin
        if (op) begin
          mv[s] = 1; mk[s] = key; e_hit = 1; e_new = 1; e_idx = s;
        end
        done = 1;
      end
    end
    if (!done && op) e_full = 1;

    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_key = key;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
    for (int j = 1; j <= 1 + e_pr; j++) begin
      @(negedge clk);
      chk(rsp_valid == (j == 1 + e_pr), "R10", "rsp_valid timing", rsp_valid,
          (j == 1 + e_pr));
    end
    chk(rsp_hit == e_hit, tag, "rsp_hit", rsp_hit, e_hit);
    chk(rsp_new == e_new, tag, "rsp_new", rsp_new, e_new);
    chk(rsp_full == e_full, tag, "rsp_full", rsp_full, e_full);
    chk(rsp_probes == 3'(e_pr), "R10", "rsp_probes", rsp_probes, e_pr);
    if (e_hit) chk(rsp_idx == IW'(e_idx), tag, "rsp_idx", rsp_idx, e_idx);
    for (int j = 0; j < hold; j++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_hit == e_hit && rsp_full == e_full &&
          rsp_probes == 3'(e_pr) && req_ready == 1'b0,
          "R11", "held result", rsp_probes, e_pr);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after consume", rsp_valid, 0);
  endtask

  initial begin
    logic [KW-1:0] ka, kb, kc, kd, ke, kf, kg, kx;
    for (int i = 0; i < D; i++) begin mv[i] = 0; mk[i] = '0; end
    ka = key_for(32'h1111_0001, 7);
    kb = key_for(32'h2222_0002, 7);
    kc = key_for(32'h3333_0003, 7);
    kd = key_for(32'h4444_0004, 7);
    ke = key_for(32'h5555_0005, 7);
    kx = key_for(32'h6666_0006, 9);
    kf = key_for(32'h7777_0007, 31);
    kg = key_for(32'h8888_0008, 31);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

    run_op(1'b0, ka, 0, "R5");        // empty table: miss after one probe (R1, R5)
    run_op(1'b1, ka, 2, "R2");        // lands in home slot 7 (R2, R6)
    chk(ref_hash(ka) == IW'(7), "R2", "bench key home", ref_hash(ka), 7);
    run_op(1'b0, ka, 0, "R3");        // lookup hit
    run_op(1'b1, ka, 1, "R7");        // duplicate insert
    run_op(1'b1, kb, 0, "R6");        // slot 8
    run_op(1'b1, kc, 0, "R4");        // slot 9
    run_op(1'b1, kd, 3, "R4");        // slot 10, four probes
    run_op(1'b1, ke, 2, "R8");        // walk exhausted
    run_op(1'b0, ke, 0, "R9");        // not stored, four probes miss (R8 unchanged)
    run_op(1'b0, kd, 0, "R3");        // deep chain hit
    run_op(1'b0, kx, 0, "R5");        // home 9: 9,10 occupied, 11 empty
    run_op(1'b1, kf, 0, "R6");        // slot 31
    run_op(1'b1, kg, 0, "R4");        // wraps to slot 0
    run_op(1'b0, kg, 1, "R4");        // wrapped lookup hit
    run_op(1'b1, kb, 0, "R7");        // existing in slot 8

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule